// File: doc/BRIEF.md
# Dual-Mode Endian Conversion Bridge

This block sits between a processor port that can run little-endian and a big-endian memory or coprocessor port. It converts every access that passes through it. A request carries an address, a size (byte, halfword or word), write data with byte strobes, a one-bit conversion attribute, and a flag that marks the request as bound for the expansion path. When the core runs little-endian, each request gets one of two conversions:

- **Address-coherent conversion** moves the access to the mirrored location inside the word. Words pass untouched, and the processor and the far side agree on whole words.
- **Data-coherent conversion** keeps the address and reorders the bytes inside the access. The processor and the far side agree on single bytes.

When the core runs big-endian, the bridge passes everything through unchanged. A small control register holds three settings: the core mode, a translation enable that lets the per-access attribute take effect, and a swap enable for the expansion path.

Both data buses use the same lane convention: lane k (bits 8k+7:8k) carries the byte at offset k of the addressed word. Under that convention every conversion is an XOR of the lane index with a code that depends on the size and the mode. The address-coherent conversion also XORs the two low address bits with the same code. A read reply passes through the same lane XOR that its request used. The bridge registers its request output, which gives one cycle of latency, and it uses valid/ready handshakes on both the request side and the reply side.

Top module: `endian_bridge`

## Requirements
- R1: After reset the control register reads as little-endian core, translation off and expansion swap on (bit0 = 0, bit1 = 0, bit2 = 1). After reset mem_valid, rsp_valid and req_err are all 0.
- R2: Address-coherent conversion with size code 0 (byte), 1 (halfword) or 2 (word) XORs the address bits [1:0] and the lane index of write data and strobes with 3, 2 or 0 respectively. A word therefore passes unchanged.
- R3: Data-coherent conversion leaves the address unchanged. It XORs the lane index of write data and strobes with 0 for a byte, 1 for a halfword and 3 for a word.
- R4: When control bit1 (translation enable) is 1, req_attr = 1 selects data-coherent conversion and req_attr = 0 selects address-coherent conversion. When bit1 is 0, req_attr is ignored and address-coherent conversion applies.
- R5: When control bit0 (big-endian core) is 1, no request is converted: address, data and strobes pass unchanged.
- R6: When control bit2 (expansion swap enable) is 0, a request with req_xpath = 1 passes unchanged. A request with req_xpath = 0 is still converted.
- R7: Read data from the far side passes through the lane XOR of the request it answers. Replies return in request order. A read of the same size and mode after a write returns the written bytes.
- R8: A request with size code 3, a halfword at an odd address, or a word whose address bits [1:0] are not 0 is accepted but not forwarded. req_err is high for exactly the one cycle after its acceptance edge.
- R9: An aligned request accepted at a clock edge shows mem_valid = 1 in the next cycle. While mem_ready is low, mem_valid and the request fields on the memory side hold steady and req_ready is 0. A reply held by rsp_ready = 0 likewise holds steady.
- R10: A control write with cfg_we = 1 takes effect for requests accepted after the edge that stores it. A request accepted at that same edge uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control value: bit0 big-endian core, bit1 translation enable, bit2 expansion swap enable |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_we | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, lane k = byte offset k |
| req_strb | input | 4 | Write byte strobes, bit k = lane k |
| req_attr | input | 1 | Per-access conversion select (1 data-coherent) |
| req_xpath | input | 1 | Request targets the expansion path |
| req_err | output | 1 | Alignment error pulse |
| mem_valid | output | 1 | Converted request valid |
| mem_ready | input | 1 | Far side accepts request |
| mem_addr | output | ADDR_W | Converted address |
| mem_size | output | 2 | Size code, unchanged |
| mem_we | output | 1 | Write flag, unchanged |
| mem_wdata | output | 32 | Converted write data |
| mem_strb | output | 4 | Converted strobes |
| mem_rvalid | input | 1 | Far side read data valid |
| mem_rready | output | 1 | Bridge takes read data |
| mem_rdata | input | 32 | Far side read data |
| rsp_valid | output | 1 | Processor reply valid |
| rsp_ready | input | 1 | Processor takes reply |
| rsp_rdata | output | 32 | Converted read data |

## Verification
The conversion is driven with byte, halfword and word accesses at several lane offsets, each with a different byte in every lane, so that a wrong lane XOR code or a missing address XOR shows up as a wrong lane or a wrong address. The same accesses are repeated with translation on and off, with the attribute at both values, in big-endian mode, and with the expansion swap cleared on both the expansion path and the normal path. This separates which control input decides the conversion. Write-then-read pairs in both little-endian modes check that the reply uses the inverse of the request's mapping. A control write placed in the same cycle as a request shows whether a mode change applies one request too early. Misaligned requests and a stalled far side cover the error path and the hold behaviour.

// File: rtl/endian_bridge_pkg.sv
package endian_bridge_pkg;

    localparam int LANES = 4;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // bit0 big-endian core, bit1 translation enable, bit2 expansion swap enable
    typedef struct packed {
        logic xbus_swap_en;
        logic xlate_en;
        logic big_endian;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{xbus_swap_en: 1'b1, xlate_en: 1'b0, big_endian: 1'b0};

    function automatic logic [DATA_W-1:0] permute_lanes(input logic [DATA_W-1:0] d,
                                                        input logic [1:0] m);
        logic [DATA_W-1:0] r;
        for (int j = 0; j < LANES; j++) r[8*j +: 8] = d[8*(j ^ int'(m)) +: 8];
        return r;
    endfunction

    function automatic logic [LANES-1:0] permute_strb(input logic [LANES-1:0] s,
                                                      input logic [1:0] m);
        logic [LANES-1:0] r;
        for (int j = 0; j < LANES; j++) r[j] = s[j ^ int'(m)];
        return r;
    endfunction

    function automatic logic is_aligned(input logic [1:0] lo, input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return ~lo[0];
            SZ_WORD: return (lo == 2'b00);
            default: return 1'b0;
        endcase
    endfunction

    // address-coherent code: mirror position inside the word
    function automatic logic [1:0] ac_code(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 2'd3;
            SZ_HALF: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // data-coherent code: reverse bytes inside the access
    function automatic logic [1:0] dc_code(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 2'd0;
            SZ_HALF: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/endian_ctrl_regs.sv
module endian_ctrl_regs
    import endian_bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_wdata,
    output ctrl_t      ctrl
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (cfg_we) ctrl_d = ctrl_t'(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    // R10: a write lands on the following cycle
    assert_cfg_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (ctrl == ctrl_t'($past(cfg_wdata))));

endmodule

// File: rtl/endian_req_stage.sv
module endian_req_stage
    import endian_bridge_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_strb,
    input  logic              req_attr,
    input  logic              req_xpath,
    output logic              req_err,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_strb,
    input  logic              fifo_full,
    output logic              push,
    output logic [1:0]        push_code
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  strb;
        logic              err;
    } req_st_t;

    req_st_t st_d, st_q;
    logic    misaligned, passthru, use_dc, accept;
    logic [1:0] lane_m, addr_m;

    always_comb begin
        misaligned = !is_aligned(req_addr[1:0], req_size);
        passthru   = ctrl.big_endian || (req_xpath && !ctrl.xbus_swap_en);
        use_dc     = ctrl.xlate_en && req_attr;
        lane_m     = passthru ? 2'd0 : (use_dc ? dc_code(req_size) : ac_code(req_size));
        addr_m     = (passthru || use_dc) ? 2'd0 : ac_code(req_size);

        req_ready  = (!st_q.valid || mem_ready) && !(!req_we && fifo_full);
        accept     = req_valid && req_ready;

        st_d     = st_q;
        st_d.err = 1'b0;
        if (st_q.valid && mem_ready) st_d.valid = 1'b0;
        if (accept && !misaligned) begin
            st_d.valid = 1'b1;
            st_d.addr  = {req_addr[ADDR_W-1:2], req_addr[1:0] ^ addr_m};
            st_d.size  = req_size;
            st_d.we    = req_we;
            st_d.wdata = permute_lanes(req_wdata, lane_m);
            st_d.strb  = permute_strb(req_strb, lane_m);
        end
        if (accept && misaligned) st_d.err = 1'b1;

        push      = accept && !misaligned && !req_we;
        push_code = lane_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_valid = st_q.valid;
    assign mem_addr  = st_q.addr;
    assign mem_size  = st_q.size;
    assign mem_we    = st_q.we;
    assign mem_wdata = st_q.wdata;
    assign mem_strb  = st_q.strb;
    assign req_err   = st_q.err;

    // R9: a stalled request holds every field
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_wdata) && $stable(mem_strb)));

    // R8: nothing misaligned reaches the far side
    assert_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> is_aligned(mem_addr[1:0], mem_size));

endmodule

// File: rtl/endian_rsp_stage.sv
module endian_rsp_stage
    import endian_bridge_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [1:0]        push_code,
    output logic              fifo_full,
    input  logic              mem_rvalid,
    output logic              mem_rready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                  valid;
        logic [DATA_W-1:0]     rdata;
        logic [DEPTH-1:0][1:0] codes;
        logic [PTR_W-1:0]      wptr;
        logic [PTR_W-1:0]      rptr;
        logic [CNT_W-1:0]      count;
    } rsp_st_t;

    rsp_st_t st_d, st_q;
    logic    pop;

    always_comb begin
        fifo_full  = (st_q.count == CNT_W'(DEPTH));
        mem_rready = (!st_q.valid || rsp_ready) && (st_q.count != '0);
        pop        = mem_rvalid && mem_rready;

        st_d = st_q;
        if (st_q.valid && rsp_ready) st_d.valid = 1'b0;
        if (pop) begin
            st_d.valid = 1'b1;
            st_d.rdata = permute_lanes(mem_rdata, st_q.codes[st_q.rptr]);
            st_d.rptr  = st_q.rptr + 1'b1;
        end
        if (push) begin
            st_d.codes[st_q.wptr] = push_code;
            st_d.wptr             = st_q.wptr + 1'b1;
        end
        st_d.count = st_q.count + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_rdata = st_q.rdata;

    // R7: the mode record never drops an outstanding read
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && fifo_full));

    // R9: a held reply stays put
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

endmodule

// File: rtl/endian_bridge.sv
module endian_bridge
    import endian_bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RD_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_strb,
    input  logic              req_attr,
    input  logic              req_xpath,
    output logic              req_err,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_we,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_strb,
    input  logic              mem_rvalid,
    output logic              mem_rready,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_rdata
);

    ctrl_t      ctrl;
    logic       fifo_full, push;
    logic [1:0] push_code;

    endian_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl)
    );

    endian_req_stage #(.ADDR_W(ADDR_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .req_strb  (req_strb),
        .req_attr  (req_attr),
        .req_xpath (req_xpath),
        .req_err   (req_err),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_strb  (mem_strb),
        .fifo_full (fifo_full),
        .push      (push),
        .push_code (push_code)
    );

    endian_rsp_stage #(.DEPTH(RD_DEPTH)) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_code  (push_code),
        .fifo_full  (fifo_full),
        .mem_rvalid (mem_rvalid),
        .mem_rready (mem_rready),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: tb/tb_endian_bridge.sv
`timescale 1ns/1ps
module tb_endian_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_strb = '0;
    logic        req_attr = 1'b0;
    logic        req_xpath = 1'b0;
    logic        req_err;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [15:0] mem_addr;
    logic [1:0]  mem_size;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_strb;
    logic        mem_rvalid = 1'b0;
    logic        mem_rready;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_rdata;

    always #5 clk = ~clk;

    endian_bridge dut (.*);

    typedef struct {
        logic [15:0] addr;
        logic [1:0]  size;
        logic        we;
        logic [31:0] wdata;
        logic [3:0]  strb;
        string       tag;
    } mem_item_t;

    typedef struct {
        logic [31:0] data;
        logic [31:0] mask;
        string       tag;
    } rsp_item_t;

    mem_item_t   exp_mem[$];
    rsp_item_t   exp_rsp[$];
    logic [31:0] rd_q[$];
    logic [7:0]  store [0:63];
    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // far-side monitor and memory model
    initial begin
        for (int i = 0; i < 64; i++) store[i] = 8'h00;
        forever begin
            @(negedge clk);
            if (rst_n && mem_valid && mem_ready) begin
                if (exp_mem.size() == 0) begin
                    check(1'b0, "unexpected far-side request", {48'h0, mem_addr}, 64'h0);
                end else begin
                    mem_item_t e;
                    e = exp_mem.pop_front();
                    check(mem_addr == e.addr && mem_size == e.size && mem_we == e.we,
                          {e.tag, " addr/size"}, {46'h0, mem_size, mem_addr},
                          {46'h0, e.size, e.addr});
                    if (e.we)
                        check(mem_wdata == e.wdata && mem_strb == e.strb,
                              {e.tag, " data/strb"}, {28'h0, mem_strb, mem_wdata},
                              {28'h0, e.strb, e.wdata});
                end
                if (mem_we) begin
                    for (int k = 0; k < 4; k++)
                        if (mem_strb[k]) store[{mem_addr[5:2], 2'(k)}] = mem_wdata[8*k +: 8];
                end else begin
                    rd_q.push_back({store[{mem_addr[5:2], 2'd3}], store[{mem_addr[5:2], 2'd2}],
                                    store[{mem_addr[5:2], 2'd1}], store[{mem_addr[5:2], 2'd0}]});
                end
            end
        end
    end

    // far-side read responder
    initial begin
        bit take;
        forever begin
            @(negedge clk);
            take = mem_rvalid && mem_rready;
            @(posedge clk);
            #1;
            if (take) void'(rd_q.pop_front());
            if (rd_q.size() > 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd_q[0];
            end else begin
                mem_rvalid = 1'b0;
            end
        end
    end

    // reply monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid && rsp_ready) begin
                if (exp_rsp.size() == 0) begin
                    check(1'b0, "unexpected reply", {32'h0, rsp_rdata}, 64'h0);
                end else begin
                    rsp_item_t r;
                    r = exp_rsp.pop_front();
                    check((rsp_rdata & r.mask) == (r.data & r.mask), {r.tag, " read data"},
                          {32'h0, rsp_rdata & r.mask}, {32'h0, r.data & r.mask});
                end
            end
        end
    end

    // driver: called just after a rising edge, returns just after the accepting edge
    task automatic xfer(input logic [15:0] a, input logic [1:0] sz, input logic we,
                        input logic [31:0] wd, input logic [3:0] st, input logic attr,
                        input logic xp, input logic [15:0] ea, input logic [31:0] ewd,
                        input logic [3:0] est, input logic [31:0] erd,
                        input logic [31:0] emask, input string tag);
        mem_item_t m;
        rsp_item_t r;
        req_valid = 1'b1; req_addr = a; req_size = sz; req_we = we;
        req_wdata = wd; req_strb = st; req_attr = attr; req_xpath = xp;
        do @(negedge clk); while (!req_ready);
        m.addr = ea; m.size = sz; m.we = we; m.wdata = ewd; m.strb = est; m.tag = tag;
        exp_mem.push_back(m);
        if (!we) begin
            r.data = erd; r.mask = emask; r.tag = tag;
            exp_rsp.push_back(r);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check(mem_valid == 1'b1, {tag, " R9 one-cycle latency"}, {63'h0, mem_valid}, 64'h1);
    endtask

    task automatic xfer_bad(input logic [15:0] a, input logic [1:0] sz, input string tag);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_we = 1'b1;
        req_wdata = 32'hFFFF_FFFF; req_strb = 4'hF; req_attr = 1'b0; req_xpath = 1'b0;
        do @(negedge clk); while (!req_ready);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        check(req_err == 1'b1 && mem_valid == 1'b0, {tag, " R8 error pulse, not forwarded"},
              {62'h0, req_err, mem_valid}, 64'h2);
        @(negedge clk);
        check(req_err == 1'b0, {tag, " R8 pulse is one cycle"}, {63'h0, req_err}, 64'h0);
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [2:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 30; i++) begin
            if (exp_mem.size() == 0 && exp_rsp.size() == 0) break;
            @(negedge clk);
        end
        check(exp_mem.size() == 0 && exp_rsp.size() == 0, "queues drained",
              {32'(exp_mem.size()), 32'(exp_rsp.size())}, 64'h0);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!mem_valid && !rsp_valid && !req_err, "R1 idle outputs in reset",
              {61'h0, mem_valid, rsp_valid, req_err}, 64'h0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1 / R4: reset mode is address-coherent with translation off, attribute ignored
        xfer(16'h0001, 2'd0, 1'b1, 32'h0000_AB00, 4'b0010, 1'b1, 1'b0,
             16'h0002, 32'h00AB_0000, 4'b0100, 32'h0, 32'h0, "R1 R2 R4 byte AC default");
        xfer(16'h0001, 2'd0, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0,
             16'h0002, 32'h0, 4'h0, 32'h0000_AB00, 32'h0000_FF00, "R7 byte AC readback");
        xfer(16'h0004, 2'd1, 1'b1, 32'h0000_1234, 4'b0011, 1'b0, 1'b0,
             16'h0006, 32'h1234_0000, 4'b1100, 32'h0, 32'h0, "R2 half AC");
        xfer(16'h0008, 2'd2, 1'b1, 32'h1122_3344, 4'hF, 1'b0, 1'b0,
             16'h0008, 32'h1122_3344, 4'hF, 32'h0, 32'h0, "R2 word AC unchanged");
        drain();

        cfg_write(3'b110);
        xfer(16'h000C, 2'd2, 1'b1, 32'hA1B2_C3D4, 4'hF, 1'b1, 1'b0,
             16'h000C, 32'hD4C3_B2A1, 4'hF, 32'h0, 32'h0, "R3 word DC");
        xfer(16'h000C, 2'd2, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0,
             16'h000C, 32'h0, 4'h0, 32'hA1B2_C3D4, 32'hFFFF_FFFF, "R7 word DC readback");
        xfer(16'h0012, 2'd1, 1'b1, 32'h5678_0000, 4'b1100, 1'b1, 1'b0,
             16'h0012, 32'h7856_0000, 4'b1100, 32'h0, 32'h0, "R3 half DC");
        xfer(16'h0012, 2'd1, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0,
             16'h0012, 32'h0, 4'h0, 32'h5678_0000, 32'hFFFF_0000, "R7 half DC readback");
        xfer(16'h0013, 2'd0, 1'b1, 32'h9A00_0000, 4'b1000, 1'b1, 1'b0,
             16'h0013, 32'h9A00_0000, 4'b1000, 32'h0, 32'h0, "R3 byte DC unchanged");
        xfer(16'h0010, 2'd0, 1'b1, 32'h0000_00EE, 4'b0001, 1'b0, 1'b0,
             16'h0013, 32'hEE00_0000, 4'b1000, 32'h0, 32'h0, "R4 attr 0 selects AC");
        xfer(16'h0014, 2'd2, 1'b1, 32'h0102_0304, 4'hF, 1'b1, 1'b1,
             16'h0014, 32'h0403_0201, 4'hF, 32'h0, 32'h0, "R6 expansion path swap on");
        drain();

        cfg_write(3'b010);
        xfer(16'h0014, 2'd1, 1'b1, 32'h0000_BEEF, 4'b0011, 1'b1, 1'b1,
             16'h0014, 32'h0000_BEEF, 4'b0011, 32'h0, 32'h0, "R6 expansion path swap off");
        xfer(16'h0014, 2'd1, 1'b1, 32'h0000_BEEF, 4'b0011, 1'b1, 1'b0,
             16'h0014, 32'h0000_EFBE, 4'b0011, 32'h0, 32'h0, "R6 normal path still converted");
        drain();

        cfg_write(3'b011);
        xfer(16'h0001, 2'd0, 1'b1, 32'h0000_CD00, 4'b0010, 1'b0, 1'b0,
             16'h0001, 32'h0000_CD00, 4'b0010, 32'h0, 32'h0, "R5 big-endian byte");
        xfer(16'h0018, 2'd2, 1'b1, 32'h0102_0304, 4'hF, 1'b1, 1'b0,
             16'h0018, 32'h0102_0304, 4'hF, 32'h0, 32'h0, "R5 big-endian word");
        drain();

        // R10: write and request in the same cycle
        cfg_we = 1'b1;
        cfg_wdata = 3'b000;
        xfer(16'h0002, 2'd0, 1'b1, 32'h0077_0000, 4'b0100, 1'b0, 1'b0,
             16'h0002, 32'h0077_0000, 4'b0100, 32'h0, 32'h0, "R10 same-edge uses old mode");
        cfg_we = 1'b0;
        xfer(16'h0002, 2'd0, 1'b1, 32'h0077_0000, 4'b0100, 1'b0, 1'b0,
             16'h0001, 32'h0000_7700, 4'b0010, 32'h0, 32'h0, "R10 next request uses new mode");
        drain();

        // R9: far side stall
        mem_ready = 1'b0;
        xfer(16'h001C, 2'd2, 1'b1, 32'hCAFE_F00D, 4'hF, 1'b0, 1'b0,
             16'h001C, 32'hCAFE_F00D, 4'hF, 32'h0, 32'h0, "R9 stalled word");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(mem_valid && mem_addr == 16'h001C && mem_wdata == 32'hCAFE_F00D && !req_ready,
                  "R9 hold under stall", {15'h0, mem_valid, mem_addr, mem_wdata},
                  {15'h0, 1'b1, 16'h001C, 32'hCAFE_F00D});
        end
        @(posedge clk);
        #1;
        mem_ready = 1'b1;
        drain();

        xfer_bad(16'h0001, 2'd1, "odd halfword");
        xfer_bad(16'h0002, 2'd2, "unaligned word");
        xfer_bad(16'h0000, 2'd3, "size code 3");
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule